// File: doc/BRIEF.md
# Seeded Random Word Generator Peripheral

This peripheral sits on a simple 32-bit register bus and produces blocks of pseudo-random words on request. Software first loads a number of seed words, one per seed slot. Once every slot has been written at least once since reset, the written seeds are folded into the generator state and the block reports that seeding is complete. Software then writes the control register with both the engine-select bit and the start bit set. The block fills its output registers with fresh words, one word per clock, and raises a completion flag in the status register.

Accesses use a single-cycle strobe. Writes take effect at the clock edge where the strobe is sampled. Reads return data combinationally from the address in that same cycle. The start bit is self-clearing. A run is refused when seeding is incomplete or the engine is not selected. Start requests that arrive while a run is in progress are stored in the register but do not restart the fill. The generator is a 32-bit xorshift (shift left 13, shift right 17, shift left 5). Its state after reset is `STATE_INIT`.

Top module: `seeded_rng_regs`

## Requirements
- R1: After reset the control register reads 0x0, the status register reads 0x1 and every output word reads 0x0.
- R2: Status bit 1 (seeding complete) is 1 only once all five seed slots (byte offsets 0x140 + 4·n, n = 0..4) have been written since reset. It stays 1 from then on.
- R3: A control write (offset 0x000) starts a run only when status bit 1 is 1 and the written value has both bit 3 (engine select) and bit 4 (start) set. Otherwise the output words and status bits 2 and 5 stay unchanged.
- R4: After any control write, the control register reads back the written value with bit 4 cleared.
- R5: Status bit 2 (busy) is 1 in the five cycles that follow the starting write. On the edge where the fifth word is stored, bit 2 returns to 0 and bit 5 (generation done) becomes 1.
- R6: When seeding completes, the generator state becomes STATE_INIT XOR all five seed words (STATE_INIT if that result is zero). Each stored word is the next xorshift32 step of the state. Output word n is read at offset 0x160 + 4·n.
- R7: A write to status (offset 0x010) loads bits 5, 4 and 3 from the written data and leaves bits 0, 1, 2 and 7 unchanged.
- R8: Reads from unmapped or misaligned offsets, including the write-only seed offsets, return 0. Writes to them change no register and do not mark a seed slot.
- R9: A control write while busy is stored (bit 4 cleared) but does not restart or extend the run in progress.
- R10: Reading output words changes neither their values nor any status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The following properties are checked in every cycle:
- A run never lasts longer than five cycles.
- The end of a run always leaves the done flag set.
- A run only begins after a qualifying control write with seeding complete.
- The seeding flag never drops.
- The start bit never reads back as set.
- The ready bit always reads as set.

The bench scenarios cover what needs a reference sequence or a specific order of accesses:
- the exact xorshift words that follow a given seed set;
- the cycle-exact busy window;
- refused starts;
- the masked status write;
- ignored unmapped accesses;
- a second start issued during a run.

// File: rtl/seeded_rng_regs.sv
module seeded_rng_regs #(
  parameter int          N_WORDS    = 5,
  parameter int          ADDR_W     = 9,
  parameter logic [31:0] STATE_INIT = 32'h6D2B_79F5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] SEED_BASE = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] OUT_BASE  = ADDR_W'('h160);
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(4 * N_WORDS);

  function automatic logic [31:0] xs_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  logic [31:0]        ctrl_q;
  logic [2:0]         flags_q;
  logic [N_WORDS-1:0] seed_mask;
  logic [31:0]        seed_acc;
  logic [31:0]        state_q;
  logic               busy;
  logic [IDX_W-1:0]   fill_idx;
  logic [31:0]        out_q [N_WORDS];

  logic [ADDR_W-1:0] seed_off, out_off;
  logic              wr, aligned, hit_seed, hit_out, seed_ok;
  logic [IDX_W-1:0]  seed_idx, out_idx;
  logic [N_WORDS-1:0] mask_nxt;
  logic [31:0]       acc_nxt, mix, gen_word;

  assign wr       = bus_sel & bus_we;
  assign aligned  = bus_addr[1:0] == 2'b00;
  assign seed_off = bus_addr - SEED_BASE;
  assign out_off  = bus_addr - OUT_BASE;
  assign hit_seed = aligned && bus_addr >= SEED_BASE && seed_off < SPAN;
  assign hit_out  = aligned && bus_addr >= OUT_BASE && out_off < SPAN;
  assign seed_idx = seed_off[IDX_W+1:2];
  assign out_idx  = out_off[IDX_W+1:2];
  assign seed_ok  = &seed_mask;
  assign acc_nxt  = seed_acc ^ bus_wdata;
  assign mix      = state_q ^ acc_nxt;
  assign gen_word = xs_step(state_q);

  always_comb begin
    mask_nxt = seed_mask;
    mask_nxt[seed_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flags_q   <= '0;
      seed_mask <= '0;
      seed_acc  <= '0;
      state_q   <= STATE_INIT;
      busy      <= 1'b0;
      fill_idx  <= '0;
      for (int i = 0; i < N_WORDS; i++) out_q[i] <= '0;
    end else begin
      if (wr && bus_addr == STAT_OFS) flags_q <= bus_wdata[5:3];
      if (wr && hit_seed) begin
        seed_mask <= mask_nxt;
        seed_acc  <= acc_nxt;
        if (&mask_nxt && !seed_ok) state_q <= (mix == '0) ? STATE_INIT : mix;
      end
      if (wr && bus_addr == CTRL_OFS) begin
        ctrl_q <= bus_wdata & ~32'h10;
        if (seed_ok && bus_wdata[3] && bus_wdata[4] && !busy) begin
          busy     <= 1'b1;
          fill_idx <= '0;
        end
      end
      if (busy) begin
        out_q[fill_idx] <= gen_word;
        state_q         <= gen_word;
        fill_idx        <= fill_idx + 1'b1;
        if (fill_idx == IDX_W'(N_WORDS - 1)) begin
          busy       <= 1'b0;
          flags_q[2] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS)      bus_rdata = ctrl_q;
    else if (bus_addr == STAT_OFS) bus_rdata = {26'b0, flags_q, busy, seed_ok, 1'b1};
    else if (hit_out)              bus_rdata = out_q[out_idx];
  end
endmodule

// File: rtl/seeded_rng_regs_chk.sv
module seeded_rng_regs_chk #(
  parameter int N_WORDS = 5,
  parameter int ADDR_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              busy,
  input logic              seed_ok,
  input logic              gen_done
);
  logic [7:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 8'(N_WORDS));

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> gen_done);

  // R3
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_we && bus_addr == '0 &&
                          bus_wdata[3] && bus_wdata[4] && seed_ok));

  // R2
  seed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ok |=> seed_ok);

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == '0) |-> !bus_rdata[4]);

  // R1
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == ADDR_W'('h10)) |->
      (bus_rdata[0] && !bus_rdata[7] && bus_rdata[2] == busy));
endmodule

bind seeded_rng_regs seeded_rng_regs_chk #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .busy(busy), .seed_ok(seed_ok), .gen_done(flags_q[2])
);

// File: tb/seeded_rng_regs_bench.sv
module seeded_rng_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT = 32'h6D2B_79F5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  seeded_rng_regs u_seeded_rng_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model;
  logic [31:0] seeds [5] = '{32'h1111_0001, 32'hA5A5_0F0F, 32'h0BAD_CAFE, 32'h1357_9BDF, 32'hFEED_0042};
  bit finished = 0;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; bus_sel = 0; bus_we = 0;
    end
  endtask

  always @(negedge clk) begin
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic run_and_check(input string tag);
    for (int i = 0; i < 5; i++) begin
      model = xs(model);
      rd(9'h160 + 9'(4*i), model, tag);
    end
  endtask

  initial begin
    logic [31:0] outs [5];
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(9'h000, 32'h0, "R1 ctrl");
    rd(9'h010, 32'h1, "R1 status");
    for (int i = 0; i < 5; i++) rd(9'h160 + 9'(4*i), 32'h0, "R1 out");
    // R8 unmapped and write-only offsets
    rd(9'h004, 32'h0, "R8 unmapped read");
    rd(9'h140, 32'h0, "R8 seed read");
    wr(9'h020, 32'hFFFF_FFFF);
    rd(9'h000, 32'h0, "R8 ctrl after stray write");
    rd(9'h010, 32'h1, "R8 status after stray write");
    // R2 partial seeding
    for (int i = 0; i < 4; i++) wr(9'h140 + 9'(4*i), seeds[i]);
    wr(9'h154, 32'h1); wr(9'h142, 32'h1);
    rd(9'h010, 32'h1, "R2/R8 partial seed");
    // R3 refused start without seeds, R4 readback
    wr(9'h000, 32'h18);
    idle(6);
    rd(9'h010, 32'h1, "R3 no run unseeded");
    rd(9'h160, 32'h0, "R3 output untouched");
    rd(9'h000, 32'h08, "R4 start bit cleared");
    wr(9'h150, seeds[4]);
    rd(9'h010, 32'h3, "R2 seeding complete");
    model = INIT;
    for (int i = 0; i < 5; i++) model ^= seeds[i];
    if (model == 0) model = INIT;
    // R3 refused start without engine select
    wr(9'h000, 32'h10);
    idle(6);
    rd(9'h010, 32'h3, "R3 no run without select");
    rd(9'h000, 32'h0, "R4 readback of 0x10");
    // R5 run timing
    wr(9'h000, 32'h18);
    for (int k = 1; k <= 5; k++) rd(9'h010, 32'h7, "R5 busy window");
    rd(9'h010, 32'h23, "R5 done after fifth word");
    rd(9'h000, 32'h08, "R4 after start");
    // R6 values
    for (int i = 0; i < 5; i++) begin model = xs(model); outs[i] = model; end
    for (int i = 0; i < 5; i++) rd(9'h160 + 9'(4*i), outs[i], "R6 output word");
    // R10 reading does not consume
    for (int i = 0; i < 5; i++) rd(9'h160 + 9'(4*i), outs[i], "R10 reread");
    rd(9'h010, 32'h23, "R10 status unchanged");
    // R7 masked status write
    wr(9'h010, 32'h38);
    rd(9'h010, 32'h3B, "R7 set three flags");
    wr(9'h010, 32'h0);
    rd(9'h010, 32'h03, "R7 clear three flags");
    wr(9'h010, 32'hFF);
    rd(9'h010, 32'h3B, "R7 all-ones write");
    wr(9'h010, 32'h0);
    // R9 start while busy
    wr(9'h000, 32'h18);
    wr(9'h000, 32'h1C);
    for (int k = 2; k <= 5; k++) rd(9'h010, 32'h7, "R9 busy not extended");
    rd(9'h010, 32'h23, "R9 done on time");
    idle(3);
    rd(9'h010, 32'h23, "R9 no second run");
    rd(9'h000, 32'h0C, "R9 busy write stored");
    run_and_check("R9/R6 continued sequence");
    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule